// File: doc/BRIEF.md
# Suspendable SHA-2 Message Feed Controller

This block sits between a message input queue and an external SHA-2 compression engine, and lets software pause a hash at a compression-block boundary and pick it up again later. Message words are pushed into a 16-word (64-byte) queue and are handed to the engine one word per accepted handshake. The controller counts how far the current compression block has been filled and keeps a running message bit length. It also holds a bank of sixteen 32-bit digest words, which the engine refreshes with its chaining state after each processed block.

A start command begins a fresh hash. A stop command does not halt at once. The controller keeps feeding words only until the current block is complete, and then waits for the engine to go idle. It then drops back to idle and raises a done status. At that point the digest words hold the full intermediate chaining state and the length output holds the bit count, so software can save both. A later continue command reloads the bit length from an input, clears the block fill count and pulses a restore strobe so that the engine reloads its chaining state from the digest words. The hash variant is captured when the hash starts or continues. Changing the mode input in the middle of a hash has no effect.

Top module: `hash_suspend_ctl`

## Requirements
- R1: The queue holds FIFO_WORDS (default 16) 32-bit words and delivers them to the engine in push order. `push_ready_o` is low exactly when the queue is full, and a push offered while full is dropped.
- R2: A start command while idle makes `busy_o` high, clears the fill count and the bit length, latches `mode_i`, and pulses `eng_init_o` high for the one cycle after the command.
- R3: Each word handed to the engine (`eng_valid_o` and `eng_ready_i` both high) adds 4 to `fill_bytes_o` and 32 to `msg_len_o`. The fill count returns to 0 after 64 bytes in SHA-256 mode (mode 2'b00) and after 128 bytes in SHA-384 mode (2'b01) and SHA-512 mode (2'b10 or 2'b11).
- R4: After a stop command, words are offered to the engine only while `fill_bytes_o` is nonzero. Once it is zero, `eng_valid_o` stays low.
- R5: While a stop is pending, the fill count is zero and `eng_idle_i` is high, the block returns to idle (`busy_o` low) and sets `done_sts_o`.
- R6: `done_sts_o` is cleared by `intr_clr_i`. A set in the same cycle wins over the clear. `intr_o` equals `done_sts_o & intr_en_i`.
- R7: While busy, an `eng_state_valid_i` pulse copies `eng_state_i[32*i +: 32]` into digest word i. In SHA-256 mode only words 0 to 7 change. In SHA-384 and SHA-512 modes all 16 words change, so all eight 64-bit state words are kept.
- R8: A continue command while idle makes the block busy, clears the fill count, loads `msg_len_o` from `msg_len_i`, latches `mode_i`, and pulses `eng_restore_o` high for the one cycle after the command.
- R9: A start or continue command while busy is ignored and sets `err_code_o` to 2'd1. An accepted start or continue sets it back to 2'd0.
- R10: A change of `mode_i` while busy changes neither `eng_mode_o`, nor the block size used by the fill count, nor the digest write-back width.
- R11: A software digest write (`dig_wr_i`) updates word `dig_idx_i` only while idle. While busy it is ignored.
- R12: A stop command while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a fresh hash (pulse) |
| stop_i | input | 1 | Request a suspend at the next block boundary (pulse) |
| continue_i | input | 1 | Resume a suspended hash (pulse) |
| mode_i | input | 2 | Hash variant: 00 SHA-256, 01 SHA-384, 1x SHA-512 |
| msg_len_i | input | 64 | Bit length reloaded on continue |
| push_valid_i | input | 1 | Message word offered to the queue |
| push_data_i | input | 32 | Message word |
| push_ready_o | output | 1 | Queue has room |
| eng_valid_o | output | 1 | Word offered to the engine |
| eng_data_o | output | 32 | Word at the head of the queue |
| eng_ready_i | input | 1 | Engine takes the offered word |
| eng_idle_i | input | 1 | Engine has no block in flight |
| eng_state_valid_i | input | 1 | Engine publishes its chaining state |
| eng_state_i | input | 512 | Chaining state from the engine |
| eng_init_o | output | 1 | Engine loads the initial hash value |
| eng_restore_o | output | 1 | Engine reloads its state from `digest_o` |
| eng_mode_o | output | 2 | Latched hash variant |
| dig_wr_i | input | 1 | Software digest word write |
| dig_idx_i | input | 4 | Digest word index |
| dig_data_i | input | 32 | Digest word data |
| digest_o | output | 512 | Digest words, word i at bits 32*i+31:32*i |
| msg_len_o | output | 64 | Running message bit length |
| fill_bytes_o | output | 8 | Bytes in the current compression block |
| busy_o | output | 1 | Hash running or stop pending |
| intr_en_i | input | 1 | Done interrupt enable |
| intr_clr_i | input | 1 | Clear done status |
| done_sts_o | output | 1 | Done status |
| intr_o | output | 1 | Done interrupt |
| err_code_o | output | 2 | 0 none, 1 command rejected while busy |

## Verification
The bench builds the controller with the default 16-word queue. At this size a SHA-256 block exactly matches the queue, while a SHA-512 or SHA-384 block needs two full refills. The stop drain therefore crosses queue-empty stalls in the wider modes and can stall on a full queue in the narrow one. With this depth, a few dozen pushes reach both the full-queue drop and the block wrap in every mode. A stop can also be issued with the fill count at any chosen value.

// File: rtl/hash_suspend_ctl.sv
module hash_suspend_ctl #(
  parameter int FIFO_WORDS = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         stop_i,
  input  logic         continue_i,
  input  logic [1:0]   mode_i,
  input  logic [63:0]  msg_len_i,
  input  logic         push_valid_i,
  input  logic [31:0]  push_data_i,
  output logic         push_ready_o,
  output logic         eng_valid_o,
  output logic [31:0]  eng_data_o,
  input  logic         eng_ready_i,
  input  logic         eng_idle_i,
  input  logic         eng_state_valid_i,
  input  logic [511:0] eng_state_i,
  output logic         eng_init_o,
  output logic         eng_restore_o,
  output logic [1:0]   eng_mode_o,
  input  logic         dig_wr_i,
  input  logic [3:0]   dig_idx_i,
  input  logic [31:0]  dig_data_i,
  output logic [511:0] digest_o,
  output logic [63:0]  msg_len_o,
  output logic [7:0]   fill_bytes_o,
  output logic         busy_o,
  input  logic         intr_en_i,
  input  logic         intr_clr_i,
  output logic         done_sts_o,
  output logic         intr_o,
  output logic [1:0]   err_code_o
);
  localparam int PTR_W = $clog2(FIFO_WORDS);
  localparam int CNT_W = $clog2(FIFO_WORDS + 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_STOP} st_e;

  st_e              st_q;
  logic [31:0]      mem [FIFO_WORDS];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic [4:0]       fill_q;
  logic [31:0]      dig_q [16];

  logic push, pop, acc_start, acc_cont, reject, done_ev;
  logic [4:0] blk_last;

  assign busy_o       = (st_q != S_IDLE);
  assign push_ready_o = (cnt_q != CNT_W'(FIFO_WORDS));
  assign eng_valid_o  = (cnt_q != '0) &&
                        ((st_q == S_RUN) || (st_q == S_STOP && fill_q != '0));
  assign eng_data_o   = mem[rd_ptr_q];
  assign push         = push_valid_i && push_ready_o;
  assign pop          = eng_valid_o && eng_ready_i;
  assign acc_start    = start_i && !busy_o;
  assign acc_cont     = continue_i && !start_i && !busy_o;
  assign reject       = (start_i || continue_i) && busy_o;
  assign done_ev      = (st_q == S_STOP) && (fill_q == '0) && eng_idle_i;
  assign blk_last     = (eng_mode_o == 2'b00) ? 5'd15 : 5'd31;
  assign fill_bytes_o = {1'b0, fill_q, 2'b00};
  assign intr_o       = done_sts_o && intr_en_i;

  always_ff @(posedge clk_i) begin
    if (push) mem[wr_ptr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (pop)  rd_ptr_q <= rd_ptr_q + 1'b1;
      cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q          <= S_IDLE;
      eng_mode_o    <= 2'b00;
      fill_q        <= '0;
      msg_len_o     <= '0;
      eng_init_o    <= 1'b0;
      eng_restore_o <= 1'b0;
      err_code_o    <= 2'd0;
      done_sts_o    <= 1'b0;
    end else begin
      eng_init_o    <= acc_start;
      eng_restore_o <= acc_cont;
      if (acc_start || acc_cont) begin
        st_q       <= S_RUN;
        eng_mode_o <= mode_i;
        fill_q     <= '0;
        msg_len_o  <= acc_start ? 64'd0 : msg_len_i;
      end else begin
        if (stop_i && st_q == S_RUN) st_q <= S_STOP;
        if (done_ev) st_q <= S_IDLE;
        if (pop) begin
          fill_q    <= (fill_q == blk_last) ? 5'd0 : fill_q + 5'd1;
          msg_len_o <= msg_len_o + 64'd32;
        end
      end
      if (reject) err_code_o <= 2'd1;
      else if (acc_start || acc_cont) err_code_o <= 2'd0;
      if (done_ev) done_sts_o <= 1'b1;
      else if (intr_clr_i) done_sts_o <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 16; i++) dig_q[i] <= '0;
    end else if (busy_o) begin
      if (eng_state_valid_i)
        for (int i = 0; i < 16; i++)
          if (i < 8 || eng_mode_o != 2'b00) dig_q[i] <= eng_state_i[32*i +: 32];
    end else if (dig_wr_i) begin
      dig_q[dig_idx_i] <= dig_data_i;
    end
  end

  always_comb begin
    for (int i = 0; i < 16; i++) digest_o[32*i +: 32] = dig_q[i];
  end

  // R1
  fifo_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(FIFO_WORDS));

  // R3
  fill_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_q <= blk_last);

  // R4
  stop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_STOP && fill_q == '0) |-> !eng_valid_o);

  // R5
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_sts_o) |-> !busy_o);

  // R8
  restore_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_restore_o |-> (busy_o && fill_q == '0));

  // R9
  reject_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && (start_i || continue_i)) |=>
      (err_code_o == 2'd1 && !eng_init_o && !eng_restore_o && busy_o));
endmodule

// File: tb/hash_suspend_ctl_tb.sv
module hash_suspend_ctl_tb_top;
  localparam int CLK_NS = 10;
  localparam int DEPTH  = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, stop = 0, cont = 0, push_valid = 0, eng_ready = 0, eng_idle = 1;
  logic st_valid = 0, dig_wr = 0, intr_en = 0, intr_clr = 0;
  logic [1:0] mode = 0;
  logic [63:0] len_in = 0;
  logic [31:0] push_data = 0, dig_data = 0;
  logic [3:0] dig_idx = 0;
  logic [511:0] st_in = 0;
  logic push_ready, eng_valid, eng_init, eng_restore, busy, done_sts, intr;
  logic [31:0] eng_data;
  logic [1:0] eng_mode, err_code;
  logic [511:0] digest;
  logic [63:0] msg_len;
  logic [7:0] fill_bytes;

  always #(CLK_NS/2) clk = ~clk;

  hash_suspend_ctl #(.FIFO_WORDS(DEPTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop), .continue_i(cont),
    .mode_i(mode), .msg_len_i(len_in), .push_valid_i(push_valid), .push_data_i(push_data),
    .push_ready_o(push_ready), .eng_valid_o(eng_valid), .eng_data_o(eng_data),
    .eng_ready_i(eng_ready), .eng_idle_i(eng_idle), .eng_state_valid_i(st_valid),
    .eng_state_i(st_in), .eng_init_o(eng_init), .eng_restore_o(eng_restore),
    .eng_mode_o(eng_mode), .dig_wr_i(dig_wr), .dig_idx_i(dig_idx), .dig_data_i(dig_data),
    .digest_o(digest), .msg_len_o(msg_len), .fill_bytes_o(fill_bytes), .busy_o(busy),
    .intr_en_i(intr_en), .intr_clr_i(intr_clr), .done_sts_o(done_sts), .intr_o(intr),
    .err_code_o(err_code));

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [31:0] seed = 32'hA000_0000;

  // reference model state
  int m_st = 0;
  logic [31:0] m_q[$];
  int m_fill = 0;
  logic [63:0] m_len = 0;
  logic [1:0] m_mode = 0, m_err = 0;
  logic [31:0] m_dig[16];
  bit m_done = 0, m_init = 0, m_rest = 0;

  task automatic chk(input string tag, input string what, input logic [511:0] act, input logic [511:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit m_ev();
    return m_q.size() > 0 && (m_st == 1 || (m_st == 2 && m_fill != 0));
  endfunction

  task automatic compare();
    logic [511:0] d;
    for (int i = 0; i < 16; i++) d[32*i +: 32] = m_dig[i];
    chk("R1", "push_ready", push_ready, m_q.size() < DEPTH);
    chk("R4", "eng_valid", eng_valid, m_ev());
    if (m_ev()) chk("R1", "eng_data", eng_data, m_q[0]);
    chk("R3", "fill_bytes", fill_bytes, 8'(m_fill * 4));
    chk("R3", "msg_len", msg_len, m_len);
    chk("R2", "busy", busy, m_st != 0);
    chk("R2", "eng_init", eng_init, m_init);
    chk("R8", "eng_restore", eng_restore, m_rest);
    chk("R10", "eng_mode", eng_mode, m_mode);
    chk("R5", "done_sts", done_sts, m_done);
    chk("R6", "intr", intr, m_done && intr_en);
    chk("R9", "err_code", err_code, m_err);
    chk("R7", "digest", digest, d);
  endtask

  task automatic tick();
    bit pop, push, acc_s, acc_c, rej, done_ev, bsy;
    int nst, nfill;
    logic [63:0] nlen;
    logic [31:0] ndig[16];
    bsy = (m_st != 0);
    pop = m_ev() && eng_ready;
    push = push_valid && (m_q.size() < DEPTH);
    acc_s = start && !bsy;
    acc_c = cont && !start && !bsy;
    rej = (start || cont) && bsy;
    done_ev = (m_st == 2) && (m_fill == 0) && eng_idle;
    nst = m_st; nfill = m_fill; nlen = m_len; ndig = m_dig;
    if (acc_s || acc_c) begin
      nst = 1; nfill = 0; nlen = acc_s ? 64'd0 : len_in;
    end else begin
      if (stop && m_st == 1) nst = 2;
      if (done_ev) nst = 0;
      if (pop) begin
        nfill = (m_fill + 1) % ((m_mode == 2'b00) ? 16 : 32);
        nlen = m_len + 64'd32;
      end
    end
    if (bsy && st_valid) begin
      for (int i = 0; i < 16; i++) if (i < 8 || m_mode != 2'b00) ndig[i] = st_in[32*i +: 32];
    end else if (!bsy && dig_wr) ndig[dig_idx] = dig_data;
    @(posedge clk);
    if (pop) void'(m_q.pop_front());
    if (push) m_q.push_back(push_data);
    if (acc_s || acc_c) m_mode = mode;
    m_st = nst; m_fill = nfill; m_len = nlen; m_dig = ndig;
    m_init = acc_s; m_rest = acc_c;
    if (rej) m_err = 2'd1; else if (acc_s || acc_c) m_err = 2'd0;
    if (done_ev) m_done = 1; else if (intr_clr) m_done = 0;
    @(negedge clk);
    compare();
    start = 0; stop = 0; cont = 0; intr_clr = 0; dig_wr = 0; st_valid = 0;
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  task automatic push_n(input int n);
    int k = 0;
    while (k < n) begin
      bit acc;
      push_valid = 1; push_data = seed;
      acc = m_q.size() < DEPTH;
      tick();
      if (acc) begin seed++; k++; end
    end
    push_valid = 0;
  endtask

  task automatic set_state(input logic [31:0] base);
    for (int i = 0; i < 16; i++) st_in[32*i +: 32] = base + 32'(i);
    st_valid = 1;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=expired expected=finished");
    summary();
  end

  initial begin
    for (int i = 0; i < 16; i++) m_dig[i] = '0;
    repeat (3) @(negedge clk);
    compare();                       // reset state
    rst_n = 1;
    tick();
    // R12: stop while idle does nothing
    stop = 1; tick();
    chk("R12", "busy after idle stop", busy, 1'b0);
    // R11: digest write while idle
    dig_wr = 1; dig_idx = 4'd3; dig_data = 32'hCAFE_0003; tick();
    chk("R11", "digest word 3 idle write", digest[96 +: 32], 32'hCAFE_0003);
    // R2: start SHA-256 with engine stalled, R1: fill queue and overflow
    eng_ready = 0; mode = 2'b00; start = 1; tick();
    push_n(DEPTH);
    push_valid = 1; push_data = 32'hDEAD_BEEF; tick(); tick(); push_valid = 0;
    chk("R1", "push_ready when full", push_ready, 1'b0);
    eng_ready = 1; run(4);
    // R9: commands while busy rejected
    start = 1; tick();
    cont = 1; tick();
    // R10: mode change mid-hash
    mode = 2'b10;
    // R7: SHA-256 write-back only low half; R11: busy write ignored
    set_state(32'h5A00_0000); tick();
    dig_wr = 1; dig_idx = 4'd12; dig_data = 32'h1111_2222; tick();
    chk("R11", "digest word 12 busy write ignored", digest[384 +: 32], 32'd0);
    run(14);
    push_n(5);
    // R4: stop with 5 words in the block, engine busy
    stop = 1; eng_idle = 0; tick();
    push_n(14);
    run(3);
    chk("R4", "halted on boundary", eng_valid, 1'b0);
    // R5/R6
    intr_en = 1; eng_idle = 1; tick();
    chk("R5", "idle after stop", busy, 1'b0);
    run(2);
    intr_clr = 1; tick();
    chk("R6", "cleared", done_sts, 1'b0);
    // R8: continue in SHA-512 mode
    mode = 2'b10; len_in = 64'h1234_0000_0000_0100; cont = 1; tick();
    run(5);
    set_state(32'h7700_0000); tick();
    push_n(40);
    stop = 1; tick();
    push_n(25);
    run(4);
    // R3/R7: SHA-384 start, full write-back
    mode = 2'b01; start = 1; tick();
    mode = 2'b00;
    set_state(32'h3840_0000); tick();
    push_n(3);
    stop = 1; eng_idle = 0; tick();
    push_n(29);
    run(3);
    // R6: set wins over clear in the same cycle
    eng_idle = 1; intr_clr = 1; tick();
    chk("R6", "set beats clear", done_sts, 1'b1);
    intr_en = 0; run(3);
    summary();
  end
endmodule